// File: doc/BRIEF.md
# Background Memory Scrubber with Exclusion Window

This block walks an ECC-protected memory of `DEPTH` words in the background. Each location is read over a simple request/grant port. The stored word is handed to an external combinational ECC decoder. When the decoder reports a correctable error, the corrected word is written back to the same location. Every corrected or uncorrectable error is reported as a one-cycle event that carries the location's address. A programmable pause separates one location from the next, so the scrub rate can be traded against memory bandwidth. A pulse marks the end of each full pass over the memory.

One address window can be withdrawn from scrubbing, for example a region whose occasional bit flips do not matter and whose traffic should stay undisturbed. Locations inside the enabled window are neither read nor reported. The window bounds and its enable are guarded: they accept new values only while scrubbing is switched off and the engine has gone idle. A write attempted at any other time is dropped and raises a sticky error flag.

Configuration is a write-only register port with five selectors:

| Selector | Field |
|---|---|
| 0 | bit 0 is the scrub enable |
| 1 | interval, in cycles |
| 2 | first excluded address |
| 3 | last excluded address |
| 4 | bit 0 is the window enable |

Top module: `scrub_engine`

## Requirements
- R1: Locations are visited in ascending address order. The pointer wraps from `DEPTH-1` to 0. Each visited location is read exactly once per pass. After a stop, the pointer resumes where it stopped.
- R2: Grants are assumed immediate. With interval register value N, the next read is granted N+3 cycles after the previous read grant when no writeback took place, and N+4 cycles after it when a writeback took place. Each skipped excluded location adds N+1 cycles. N=0 gives the densest scrubbing.
- R3: Decoder status 2'b01 means correctable. For such a location, the decoder's corrected word is written to the same address. Two cycles after the read grant, `evt_valid` pulses with `evt_fatal`=0 and that address.
- R4: While the window enable is 1, every location with low <= address <= high (inclusive) is neither read nor reported, and its stored contents stay untouched.
- R5: Writes to selectors 2, 3 and 4 are accepted only while the scrub enable is 0 and the engine is idle. Any other such write is ignored and sets `cfg_err`, which stays 1 until reset. Selectors 0 and 1 are always accepted.
- R6: `pass_done` pulses for one cycle in the cycle after location `DEPTH-1` finishes. A location finishes at its check cycle when no writeback takes place, and at its write grant otherwise.
- R7: No write is issued for status 2'b00 (clean) or for status 2'b10 or 2'b11 (uncorrectable). An uncorrectable location gives a single `evt_valid` pulse with `evt_fatal`=1 and its address, two cycles after the read grant.
- R8: Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle `mem_gnt` is seen. At most one access is outstanding.
- R9: Clearing the scrub enable lets the engine finish the location in progress, including its writeback. No further request is made after that.
- R10: After reset, `mem_req`, `evt_valid`, `pass_done` and `cfg_err` are 0. Scrubbing and the window are disabled, and the interval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field selector |
| cfg_wdata | input | CFW | Configuration write data |
| cfg_err | output | 1 | Sticky flag: a guarded field was written while active |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for writeback, 0 for read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | CW | Writeback word |
| mem_gnt | input | 1 | Grant; completes the access in the same cycle |
| mem_rdata | input | CW | Read word, valid while a read is granted |
| chk_word | output | CW | Captured word presented to the ECC decoder |
| chk_status | input | 2 | Decoder result: 00 clean, 01 corrected, 1x uncorrectable |
| chk_fixed | input | CW | Decoder's corrected word |
| evt_valid | output | 1 | Error event pulse |
| evt_fatal | output | 1 | 1 for uncorrectable, 0 for corrected |
| evt_addr | output | AW | Address of the reported location |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The assertions check the following on every cycle:
- the request is held steady until it is granted;
- the guarded window fields stay frozen after a rejected write, and the error flag stays sticky;
- no event ever names an address inside the enabled window;
- a read only starts once the pause counter has expired;
- the pass pulse coincides with the pointer at zero.

Other behaviours need the bench's scenarios: the exact visiting order, the pause lengths, the writeback contents, the untouched contents of excluded words, and clean resumption after a stop. The bench's reference model predicts each grant, event and pass pulse under several intervals, grant stalls and window settings, and compares them cycle by cycle.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GAP  = 3'd1,
    ST_RD   = 3'd2,
    ST_CHK  = 3'd3,
    ST_WR   = 3'd4
  } scrub_state_t;

  localparam logic [1:0] CHK_CLEAN = 2'b00;
  localparam logic [1:0] CHK_FIXED = 2'b01;

  localparam logic [2:0] SEL_RUN = 3'd0;
  localparam logic [2:0] SEL_GAP = 3'd1;
  localparam logic [2:0] SEL_XLO = 3'd2;
  localparam logic [2:0] SEL_XHI = 3'd3;
  localparam logic [2:0] SEL_XEN = 3'd4;

endpackage

// File: rtl/scrub_cfg.sv
module scrub_cfg
  import scrub_pkg::*;
#(
  parameter int AW  = 4,
  parameter int GW  = 8,
  parameter int CFW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2:0]     sel,
  input  logic [CFW-1:0] wdata,
  input  logic           busy,
  output logic           run,
  output logic [GW-1:0]  gap,
  output logic [AW-1:0]  xlo,
  output logic [AW-1:0]  xhi,
  output logic           xen,
  output logic           err
);

  logic          run_q, run_d, xen_q, xen_d, err_q, err_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [AW-1:0] xlo_q, xlo_d, xhi_q, xhi_d;
  logic          guarded, locked, reject;

  always_comb begin
    guarded = (sel == SEL_XLO) || (sel == SEL_XHI) || (sel == SEL_XEN);
    locked  = run_q || busy;
    reject  = we && guarded && locked;
    run_d = run_q;
    gap_d = gap_q;
    xlo_d = xlo_q;
    xhi_d = xhi_q;
    xen_d = xen_q;
    err_d = err_q | reject;
    if (we && !reject) begin
      case (sel)
        SEL_RUN: run_d = wdata[0];
        SEL_GAP: gap_d = wdata[GW-1:0];
        SEL_XLO: xlo_d = wdata[AW-1:0];
        SEL_XHI: xhi_d = wdata[AW-1:0];
        SEL_XEN: xen_d = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      gap_q <= '0;
      xlo_q <= '0;
      xhi_q <= '0;
      xen_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      run_q <= run_d;
      gap_q <= gap_d;
      xlo_q <= xlo_d;
      xhi_q <= xhi_d;
      xen_q <= xen_d;
      err_q <= err_d;
    end
  end

  assign run = run_q;
  assign gap = gap_q;
  assign xlo = xlo_q;
  assign xhi = xhi_q;
  assign xen = xen_q;
  assign err = err_q;

  // A guarded write while active leaves the window untouched and flags it
  assert_window_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && guarded && (run_q || busy)) |=>
      ($stable(xlo_q) && $stable(xhi_q) && $stable(xen_q) && err_q));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [GW-1:0] limit,
  output logic          done
);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = (cnt_q >= limit);
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (tick && !done)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          xen,
  input  logic [AW-1:0] xlo,
  input  logic [AW-1:0] xhi,
  output logic [AW-1:0] addr,
  output logic          excluded,
  output logic          wrapped
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          wrap_q, wrap_d;

  always_comb begin
    excluded = xen && (ptr_q >= xlo) && (ptr_q <= xhi);
    wrap_d   = step && (ptr_q == LAST);
    ptr_d    = ptr_q;
    if (step)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      wrap_q <= wrap_d;
    end
  end

  assign addr    = ptr_q;
  assign wrapped = wrap_q;

  assert_wrap_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (ptr_q == '0));

endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int GW    = 8,
  parameter int CFW   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_sel,
  input  logic [CFW-1:0] cfg_wdata,
  output logic           cfg_err,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [CW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic [CW-1:0]  mem_rdata,
  output logic [CW-1:0]  chk_word,
  input  logic [1:0]     chk_status,
  input  logic [CW-1:0]  chk_fixed,
  output logic           evt_valid,
  output logic           evt_fatal,
  output logic [AW-1:0]  evt_addr,
  output logic           pass_done
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  scrub_state_t  st_q, st_d;
  logic          run, xen, excluded, pace_done;
  logic [GW-1:0] gap;
  logic [AW-1:0] xlo, xhi, ptr;
  logic          step, pace_clr, pace_tick, cap_en, wd_en, busy;
  logic [CW-1:0] rd_q, wd_q;
  logic          evt_v_q, evt_f_q, evt_d;
  logic [AW-1:0] evt_a_q;

  assign busy = (st_q != ST_IDLE);

  scrub_cfg #(.AW(AW), .GW(GW), .CFW(CFW)) u_cfg (
    .clk(clk), .rst_n(rst_q), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .busy(busy), .run(run), .gap(gap), .xlo(xlo), .xhi(xhi), .xen(xen),
    .err(cfg_err)
  );

  scrub_pacer #(.GW(GW)) u_pacer (
    .clk(clk), .rst_n(rst_q), .clr(pace_clr), .tick(pace_tick),
    .limit(gap), .done(pace_done)
  );

  scrub_walker #(.DEPTH(DEPTH), .AW(AW)) u_walker (
    .clk(clk), .rst_n(rst_q), .step(step), .xen(xen), .xlo(xlo), .xhi(xhi),
    .addr(ptr), .excluded(excluded), .wrapped(pass_done)
  );

  always_comb begin
    st_d      = st_q;
    step      = 1'b0;
    pace_clr  = 1'b0;
    pace_tick = 1'b0;
    cap_en    = 1'b0;
    wd_en     = 1'b0;
    evt_d     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        pace_clr = 1'b1;
        if (run) st_d = ST_GAP;
      end
      ST_GAP: begin
        if (!run) begin
          st_d = ST_IDLE;
        end else if (pace_done) begin
          pace_clr = 1'b1;
          if (excluded) step = 1'b1;
          else          st_d = ST_RD;
        end else begin
          pace_tick = 1'b1;
        end
      end
      ST_RD: begin
        if (mem_gnt) begin
          cap_en = 1'b1;
          st_d   = ST_CHK;
        end
      end
      ST_CHK: begin
        evt_d = (chk_status != CHK_CLEAN);
        if (chk_status == CHK_FIXED) begin
          wd_en = 1'b1;
          st_d  = ST_WR;
        end else begin
          step     = 1'b1;
          pace_clr = 1'b1;
          st_d     = run ? ST_GAP : ST_IDLE;
        end
      end
      ST_WR: begin
        if (mem_gnt) begin
          step     = 1'b1;
          pace_clr = 1'b1;
          st_d     = run ? ST_GAP : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q    <= ST_IDLE;
      rd_q    <= '0;
      wd_q    <= '0;
      evt_v_q <= 1'b0;
      evt_f_q <= 1'b0;
      evt_a_q <= '0;
    end else begin
      st_q    <= st_d;
      if (cap_en) rd_q <= mem_rdata;
      if (wd_en)  wd_q <= chk_fixed;
      evt_v_q <= evt_d;
      if (evt_d) begin
        evt_f_q <= chk_status[1];
        evt_a_q <= ptr;
      end
    end
  end

  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = ptr;
  assign mem_wdata = wd_q;
  assign chk_word  = rd_q;
  assign evt_valid = evt_v_q;
  assign evt_fatal = evt_f_q;
  assign evt_addr  = evt_a_q;

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && !mem_gnt) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_event_in_window_R4: assert property (@(posedge clk) disable iff (!rst_q)
    evt_v_q |-> !(xen && (evt_a_q >= xlo) && (evt_a_q <= xhi)));

  assert_no_write_when_unfixable_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_CHK && chk_status != CHK_FIXED) |=> !mem_req);

  assert_read_after_pause_R2: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(mem_req) && !mem_we && $past(st_q) == ST_GAP) |-> $past(pace_done));

endmodule

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
  localparam int DEPTH = 16, AW = 4, CW = 16, GW = 8, CFW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic           cfg_we;
  logic [2:0]     cfg_sel;
  logic [CFW-1:0] cfg_wdata;
  logic           cfg_err, mem_req, mem_we, evt_valid, evt_fatal, pass_done;
  logic [AW-1:0]  mem_addr, evt_addr;
  logic [CW-1:0]  mem_wdata, chk_word, chk_fixed;
  logic           mem_gnt = 1'b0;
  logic [CW-1:0]  mem_rdata = '0;
  logic [1:0]     chk_status;

  scrub_engine #(.DEPTH(DEPTH), .CW(CW), .GW(GW), .CFW(CFW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .chk_word(chk_word),
    .chk_status(chk_status), .chk_fixed(chk_fixed), .evt_valid(evt_valid),
    .evt_fatal(evt_fatal), .evt_addr(evt_addr), .pass_done(pass_done)
  );

  // test decoder: top two bits encode the injected error kind
  always_comb begin
    case (chk_word[CW-1:CW-2])
      2'b00:   chk_status = 2'b00;
      2'b01:   chk_status = 2'b01;
      default: chk_status = 2'b10;
    endcase
    chk_fixed = {2'b00, chk_word[CW-3:0]};
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model state
  logic [CW-1:0] mem [DEPTH];
  int  m_ptr = 0, m_lo = 0, m_hi = 0, m_gap = 0;
  bit  m_xen = 0;
  int  stall = 0, wait_c = 0, cyc = 0;
  int  exp_evt_cyc = -1, exp_evt_addr = 0, exp_pass_cyc = -1;
  bit  exp_evt_fatal = 0, exp_wr = 0;
  int  exp_wr_addr = 0;
  logic [CW-1:0] exp_wd = '0;
  bit  have_prev = 0, prev_wrote = 0, prev_wait = 0;
  int  prev_rd_cyc = 0, pass_seen = 0, pass_exp = 0, req_count = 0;
  logic [AW-1:0] prev_addr = '0;
  logic          prev_we = 1'b0;
  logic [CW-1:0] prev_wd = '0;

  function automatic bit in_win(input int a);
    return m_xen && a >= m_lo && a <= m_hi;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit g;
      cyc++;
      if (prev_wait)
        check(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
              "R8 request held", int'(mem_addr), int'(prev_addr));
      if (evt_valid || cyc == exp_evt_cyc) begin
        check(evt_valid && cyc == exp_evt_cyc, exp_evt_fatal ? "R7 event timing" : "R3 event timing",
              int'(evt_valid), int'(cyc == exp_evt_cyc));
        if (evt_valid && cyc == exp_evt_cyc)
          check(evt_fatal == exp_evt_fatal && int'(evt_addr) == exp_evt_addr,
                exp_evt_fatal ? "R7 event fields" : "R3 event fields",
                {evt_fatal, evt_addr}, {exp_evt_fatal, exp_evt_addr[AW-1:0]});
      end
      if (pass_done || cyc == exp_pass_cyc)
        check(pass_done && cyc == exp_pass_cyc, "R6 pass pulse", int'(pass_done), int'(cyc == exp_pass_cyc));
      if (pass_done) pass_seen++;

      if (mem_req) begin
        req_count++;
        if (wait_c >= stall) begin g = 1; wait_c = 0; end
        else begin g = 0; wait_c++; end
      end else begin
        g = 0; wait_c = 0;
      end
      mem_gnt   = g;
      mem_rdata = mem[mem_addr];
      prev_wait = mem_req && !g;
      prev_addr = mem_addr;
      prev_we   = mem_we;
      prev_wd   = mem_wdata;

      if (mem_req && g) begin
        if (!mem_we) begin
          int a, skipped;
          logic [CW-1:0] w;
          a = m_ptr; skipped = 0;
          while (in_win(a)) begin a = (a + 1) % DEPTH; skipped++; end
          check(!exp_wr, "R3 writeback missing", 0, 1);
          exp_wr = 0;
          check(int'(mem_addr) == a, "R1 visit order", int'(mem_addr), a);
          check(!in_win(int'(mem_addr)), "R4 excluded read", int'(mem_addr), a);
          if (have_prev && stall == 0)
            check(cyc - prev_rd_cyc == m_gap + 3 + int'(prev_wrote) + skipped * (m_gap + 1),
                  "R2 spacing", cyc - prev_rd_cyc,
                  m_gap + 3 + int'(prev_wrote) + skipped * (m_gap + 1));
          have_prev = 1; prev_rd_cyc = cyc; prev_wrote = 0;
          w = mem[mem_addr];
          if (w[CW-1:CW-2] == 2'b01) begin
            exp_wr = 1; exp_wr_addr = int'(mem_addr); exp_wd = {2'b00, w[CW-3:0]};
            exp_evt_cyc = cyc + 2; exp_evt_fatal = 0; exp_evt_addr = int'(mem_addr);
          end else if (w[CW-1]) begin
            exp_evt_cyc = cyc + 2; exp_evt_fatal = 1; exp_evt_addr = int'(mem_addr);
          end
          if (w[CW-1:CW-2] != 2'b01 && int'(mem_addr) == DEPTH - 1) begin
            exp_pass_cyc = cyc + 2; pass_exp++;
          end
          m_ptr = (int'(mem_addr) + 1) % DEPTH;
        end else begin
          check(exp_wr && int'(mem_addr) == exp_wr_addr && mem_wdata == exp_wd,
                exp_wr ? "R3 writeback" : "R7 unexpected write", int'(mem_wdata), int'(exp_wd));
          mem[mem_addr] = mem_wdata;
          exp_wr = 0; prev_wrote = 1;
          if (int'(mem_addr) == DEPTH - 1) begin exp_pass_cyc = cyc + 1; pass_exp++; end
        end
      end
    end
  end

  task automatic cfg_write(input logic [2:0] s, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = CFW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    int rc;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0A00 + CW'(i);
    mem[3] = 16'h4123;
    mem[9] = 16'h8077;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(!mem_req && !evt_valid && !pass_done, "R10 idle outputs", {mem_req, evt_valid, pass_done}, 0);
    check(!cfg_err, "R10 error flag clear", int'(cfg_err), 0);

    // window programmed while idle, left disabled
    cfg_write(3'd2, 4); cfg_write(3'd3, 7);
    m_lo = 4; m_hi = 7;
    check(!cfg_err, "R5 idle write accepted", int'(cfg_err), 0);
    cfg_write(3'd1, 2); m_gap = 2;
    have_prev = 0;
    cfg_write(3'd0, 1);
    while (pass_seen < 2) @(negedge clk);
    check(mem[3] == 16'h0123, "R3 memory corrected", int'(mem[3]), 16'h0123);
    check(mem[9] == 16'h8077, "R7 uncorrectable untouched", int'(mem[9]), 16'h8077);

    // guarded write while active is refused; reads of 4..7 keep happening
    cfg_write(3'd4, 1);
    check(cfg_err, "R5 rejected write flagged", int'(cfg_err), 1);
    mem[5] = 16'h4055;
    stall = 2; have_prev = 0;
    cfg_write(3'd1, 0); m_gap = 0; have_prev = 0;
    repeat (80) @(negedge clk);
    check(mem[5] == 16'h0055, "R4 window ignored when not enabled", int'(mem[5]), 16'h0055);

    // stop and confirm quiescence
    cfg_write(3'd0, 0);
    repeat (20) @(negedge clk);
    rc = req_count;
    repeat (30) @(negedge clk);
    check(req_count == rc, "R9 no request after stop", req_count - rc, 0);

    // enable the window while idle, inject errors inside and outside it
    mem[5] = 16'h4066; mem[3] = 16'h4033;
    cfg_write(3'd4, 1); m_xen = 1;
    check(cfg_err, "R5 flag sticky", int'(cfg_err), 1);
    stall = 0; have_prev = 0;
    cfg_write(3'd0, 1);
    rc = pass_seen;
    while (pass_seen < rc + 2) @(negedge clk);
    cfg_write(3'd0, 0);
    repeat (30) @(negedge clk);
    check(mem[5] == 16'h4066, "R4 excluded word untouched", int'(mem[5]), 16'h4066);
    check(mem[3] == 16'h0033, "R3 corrected outside window", int'(mem[3]), 16'h0033);
    check(pass_seen == pass_exp, "R6 pass count", pass_seen, pass_exp);
    check(!exp_wr, "R9 writeback finished", int'(exp_wr), 0);
    wrap_up();
  end

endmodule